// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block is the digital core of a phase-locked loop's phase comparator. It watches two single-bit inputs, a reference signal and the feedback signal coming back from the oscillator divider, on a fast system clock. Only rising edges count. Whichever input produces an edge first leaves a pending correction in a small memory. The correction stays until the other input catches up with an edge of its own. Because of this the detector responds to frequency as well as phase, settles at zero phase offset, and cannot be fooled by a harmonic.

The error output has three states, carried on two bits. When `err_drive` is low the output floats and the loop filter holds its charge. When `err_drive` is high, `err_level` selects between pushing the control voltage up (speed up) and pulling it down (slow down). A separate `lock_pulse` output is high while no correction is active. In a locked loop it is therefore high almost all the time, and it drops once for each correction pulse.

Each input passes through its own synchronizer and rising-edge detector before it reaches the two-flag memory. A new input level therefore reaches the outputs after a fixed latency. The reset is asynchronous and active low.

Top module: `edge_pfd`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises with both inputs low, `err_drive` = 0, `err_level` = 0 and `lock_pulse` = 1. Reset clears the synchronizers, the edge detectors and both flags.
- R2: With no correction active, a rising edge on `ref_in` makes the output push high (`err_drive` = 1, `err_level` = 1). This takes effect on the (SYNC_STAGES+1)-th rising clock edge, counting the first edge that samples the new level as edge 1. That is the third edge with the default of two stages.
- R3: With no correction active, a rising edge on `fb_in` makes the output pull low (`err_drive` = 1, `err_level` = 0), with the same latency as R2.
- R4: While a correction is active, an edge on the opposite input ends it. The output returns to floating (`err_drive` = 0) with the same latency. A push-high and a pull-low correction are never active together.
- R5: Rising edges on both inputs in the same clock cycle set no correction, and the output keeps floating. Inputs with identical edges (zero phase offset) never produce a correction.
- R6: `lock_pulse` is 1 exactly in the cycles where `err_drive` is 0.
- R7: Falling edges, and how long either input stays high, have no effect. Two inputs with the same rising edges but different duty cycles give the same output sequence.
- R8: A reference at twice the feedback frequency, with its first edge leading, never produces a pull-low cycle and produces push-high cycles in every feedback period.
- R9: While `ref_in` shows no rising edge, one `fb_in` edge leaves the output pulling low. It stays there through any further `fb_in` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| fb_in | input | 1 | Feedback signal from the oscillator, asynchronous to clk |
| err_drive | output | 1 | 1 = error output driven, 0 = high impedance |
| err_level | output | 1 | Level while driven: 1 = speed up, 0 = slow down |
| lock_pulse | output | 1 | 1 while no correction is active |

## Verification
The inputs are driven as square waves from a table of directed cases and from random ones, and a cycle-by-cycle model of the edge memory follows them.

- Single isolated edges on each input fix the exact latency and the sign of each correction.
- Coincident edges and identical waves show that matched phase gives no correction.
- Waves with the same edges but different duty cycles must give identical push and pull counts, which shows that only rising edges matter.
- A reference at twice the feedback rate separates a true frequency detector from one that settles on a harmonic.
- A silent reference shows that the output parks at the slow-down level.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // {drive, level} coding of the three-state error output
  typedef enum logic [1:0] {
    ERR_FLOAT   = 2'b00,
    ERR_PULL_LO = 2'b10,
    ERR_PUSH_HI = 2'b11
  } err_code_e;

  // pending corrections held by the edge memory
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

  localparam int unsigned PFD_NUM_CH   = 2;
  localparam int unsigned PFD_CH_REF   = 0;
  localparam int unsigned PFD_CH_FB    = 1;

endpackage

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   samp_en;

  // synchronizer chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = din;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  assign samp_en = 1'b1;
  assign prev_d  = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else if (samp_en) begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // R7: a held-high level yields exactly one edge strobe
  a_r7_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output pfd_flags_t flags
);

  pfd_flags_t flags_q;
  pfd_flags_t flags_d;
  logic       flag_en;
  logic       nxt_up;
  logic       nxt_dn;

  always_comb begin
    nxt_up  = flags_q.up | ref_rise;
    nxt_dn  = flags_q.dn | fb_rise;
    flag_en = ref_rise | fb_rise;
    if (nxt_up && nxt_dn) begin
      flags_d = '0;
    end else begin
      flags_d.up = nxt_up;
      flags_d.dn = nxt_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.up && flags_q.dn));

  a_r2_ref_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !flags_q.dn) |=> flags_q.up);

  a_r3_fb_sets_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !flags_q.up) |=> flags_q.dn);

  a_r4_fb_ends_up: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.up && fb_rise && !ref_rise) |=> (!flags_q.up && !flags_q.dn));

  a_r5_coincident_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise && !flags_q.up && !flags_q.dn) |=> (!flags_q.up && !flags_q.dn));

  a_r9_dn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.dn && !ref_rise) |=> flags_q.dn);

endmodule

// File: rtl/pfd_err_encode.sv
module pfd_err_encode
  import pfd_pkg::*;
(
  input  pfd_flags_t flags,
  output logic       drive,
  output logic       level,
  output logic       lock
);

  err_code_e code;

  always_comb begin
    unique case ({flags.up, flags.dn})
      2'b10:   code = ERR_PUSH_HI;
      2'b01:   code = ERR_PULL_LO;
      default: code = ERR_FLOAT;
    endcase
  end

  assign {drive, level} = code;
  assign lock           = (code == ERR_FLOAT);

endmodule

// File: rtl/edge_pfd.sv
module edge_pfd
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic err_drive,
  output logic err_level,
  output logic lock_pulse
);

  logic [PFD_NUM_CH-1:0] raw_in;
  logic [PFD_NUM_CH-1:0] ch_rise;
  pfd_flags_t            flags;

  assign raw_in[PFD_CH_REF] = ref_in;
  assign raw_in[PFD_CH_FB]  = fb_in;

  for (genvar c = 0; c < PFD_NUM_CH; c++) begin : g_ch
    pfd_edge_sense #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[c]),
      .rise (ch_rise[c])
    );
  end

  pfd_flag_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ch_rise[PFD_CH_REF]),
    .fb_rise (ch_rise[PFD_CH_FB]),
    .flags   (flags)
  );

  pfd_err_encode u_enc (
    .flags(flags),
    .drive(err_drive),
    .level(err_level),
    .lock (lock_pulse)
  );

  // R6: lock indication drops for every driven cycle
  a_r6_lock_vs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_pulse != err_drive));

endmodule

// File: tb/sim_edge_pfd.sv
module sim_edge_pfd;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic err_drive, err_level, lock_pulse;

  int n_tests = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  edge_pfd #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .err_drive(err_drive), .err_level(err_level), .lock_pulse(lock_pulse)
  );

  // bench model of the requirements: two-stage sync, edge strobe, two flags
  logic mr0, mr1, mrl, mf0, mf1, mfl, m_up, m_dn;
  wire  m_rr = mr1 & ~mrl;
  wire  m_fr = mf1 & ~mfl;

  function automatic logic [1:0] next_flags(logic up, logic dn, logic rr, logic fr);
    logic u, d;
    u = up | rr;
    d = dn | fr;
    if (u && d) return 2'b00;
    return {u, d};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mr0, mr1, mrl, mf0, mf1, mfl, m_up, m_dn} <= '0;
    end else begin
      mr0 <= ref_in; mr1 <= mr0; mrl <= mr1;
      mf0 <= fb_in;  mf1 <= mf0; mfl <= mf1;
      {m_up, m_dn} <= next_flags(m_up, m_dn, m_rr, m_fr);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      if (m_up)
        check(err_drive && err_level, "R2", "push-high {drive,level}",
              {err_drive, err_level}, 3);
      else if (m_dn)
        check(err_drive && !err_level, "R3", "pull-low {drive,level}",
              {err_drive, err_level}, 2);
      else
        check(!err_drive, "R4", "float drive", err_drive, 0);
      check(lock_pulse == !(m_up | m_dn), "R6", "lock_pulse", lock_pulse, !(m_up | m_dn));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_waves(int cyc, int rp, int rh, int roff, bit ren,
                           int fp, int fh, int foff, bit fen,
                           output int ups, output int dns);
    ups = 0; dns = 0;
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      if (err_drive && err_level) ups++;
      if (err_drive && !err_level) dns++;
      ref_in = ren && (((t + roff) % rp) < rh);
      fb_in  = fen && (((t + foff) % fp) < fh);
    end
  endtask

  initial begin
    int ua, da, ub, db;
    void'($urandom(32'd4046));

    // R1: reset state, with an input held high during reset
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    check(!err_drive && !err_level && lock_pulse, "R1", "outputs in reset",
          {err_drive, err_level, lock_pulse}, 1);
    do_reset();
    repeat (2) @(negedge clk);
    check(!err_drive && !err_level && lock_pulse, "R1", "outputs after reset",
          {err_drive, err_level, lock_pulse}, 1);
    cmp_en = 1'b1;

    // R2 latency: edge k samples, change visible after edge k+2
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); check(!err_drive, "R2", "no change after 1 edge", err_drive, 0);
    @(negedge clk); check(!err_drive, "R2", "no change after 2 edges", err_drive, 0);
    @(negedge clk); check(err_drive && err_level, "R2", "push-high after 3 edges",
                          {err_drive, err_level}, 3);
    // R7: falling edge on ref keeps correction
    ref_in = 1'b0;
    repeat (4) @(negedge clk);
    check(err_drive && err_level, "R7", "ref fall ignored", {err_drive, err_level}, 3);
    // R4: feedback edge ends it
    fb_in = 1'b1;
    repeat (3) @(negedge clk);
    check(!err_drive && lock_pulse, "R4", "float after opposing edge", err_drive, 0);

    // R3 and R9
    do_reset();
    @(negedge clk); fb_in = 1'b1;
    repeat (2) @(negedge clk);
    check(!err_drive, "R3", "no change after 2 edges", err_drive, 0);
    @(negedge clk);
    check(err_drive && !err_level, "R3", "pull-low after 3 edges", {err_drive, err_level}, 2);
    run_waves(300, 20, 10, 0, 1'b0, 30, 15, 0, 1'b1, ua, da);
    check(da == 300 && ua == 0, "R9", "pull-low cycles with silent ref", da, 300);
    check(err_drive && !err_level, "R9", "still pulling low", {err_drive, err_level}, 2);

    // R5: coincident edges and identical waves
    do_reset();
    @(negedge clk); ref_in = 1'b1; fb_in = 1'b1;
    repeat (6) @(negedge clk);
    check(!err_drive && lock_pulse, "R5", "coincident edges float", err_drive, 0);
    run_waves(400, 25, 12, 0, 1'b1, 25, 12, 0, 1'b1, ua, da);
    check(ua == 0 && da == 0, "R5", "zero-phase driven cycles", ua + da, 0);

    // R7: same edges, different duty cycles
    do_reset();
    run_waves(400, 20, 5, 0, 1'b1, 40, 10, 7, 1'b1, ua, da);
    do_reset();
    run_waves(400, 20, 15, 0, 1'b1, 40, 30, 7, 1'b1, ub, db);
    check(ua == ub, "R7", "push-high count vs duty", ub, ua);
    check(da == db, "R7", "pull-low count vs duty", db, da);

    // R8: reference at twice the feedback rate
    do_reset();
    run_waves(800, 20, 10, 0, 1'b1, 40, 20, 35, 1'b1, ua, da);
    check(da == 0, "R8", "pull-low cycles on harmonic", da, 0);
    check(ua >= 20 * 5, "R8", "push-high cycles on harmonic", ua, 100);

    // random waves, checked by the model each cycle (R2 R3 R4 R6)
    for (int it = 0; it < 12; it++) begin
      int rp, fp;
      rp = 6 + int'($urandom_range(40));
      fp = 6 + int'($urandom_range(40));
      do_reset();
      run_waves(1500, rp, 1 + int'($urandom_range(rp - 2)), int'($urandom_range(rp)), 1'b1,
                fp, 1 + int'($urandom_range(fp - 2)), int'($urandom_range(fp)), 1'b1, ua, da);
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule